// File: doc/BRIEF.md
# Windowed Outbound Address Translator

This block maps a narrow memory-mapped slave address onto a wide PCI Express address. The incoming address is split in two. The low field passes through untouched, so it gives an offset inside a window. The high field picks one row of a small translation table. That row holds the replacement upper address bits and a 2-bit code for the target address space. The translated address, the space code and a range-error flag are presented one registered cycle after the request is accepted.

Requests enter and results leave on valid/ready streams. The input is accepted when `req_ready` is high, and `req_ready` is high whenever the output register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the result holds steady and no new request is taken. The table has its own write port, which is plain and has no handshake. Software can reload any row at run time. When a row is written in the same cycle that a lookup of that row is accepted, the lookup returns the row's old contents. On builds where the output address is wider than 32 bits, the bits above bit 31 are forced to zero unless the row's space code marks 64-bit memory.

Top module: `xlat_window`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1, and every table row holds zero upper bits with space code 00.
- R2: Output address bits N-1..0 equal the accepted request's address bits N-1..0.
- R3: Request address bits M-1..N form the row index, and output address bits P-1..N equal the upper-bits field of that row.
- R4: `rsp_space` carries the selected row's 2-bit space code unchanged. The codes are 00 for 32-bit memory, 01 for 64-bit memory, 10 for I/O and 11 reserved.
- R5: A request accepted on clock edge k appears with `rsp_valid` high directly after edge k.
- R6: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0 and `rsp_addr`, `rsp_space` and `rsp_err` hold their values.
- R7: A table write to a row accepted on the same edge as a lookup of that row leaves the lookup with the old contents. The next lookup sees the new contents.
- R8: An index of Q or more is clamped to row Q-1, and `rsp_err` is 1. An index below Q gives `rsp_err` 0.
- R9: A table write whose index is Q or more changes no row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request address is present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | M | Slave-side address |
| rsp_valid | output | 1 | Translated result is present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | P | Translated address |
| rsp_space | output | 2 | Space code of the selected row |
| rsp_err | output | 1 | Index was out of range and was clamped |
| tbl_we | input | 1 | Table row write strobe |
| tbl_idx | input | M-N | Row to write |
| tbl_hi | input | P-N | New upper address bits for the row |
| tbl_space | input | 2 | New space code for the row |

## Verification
Every result is due exactly one edge after the request is accepted. The bench drives each request on a falling edge and reads the outputs on the next falling edge, so the single output register lies between stimulus and sample. A table write lands on the edge where it is driven. So the same-edge case reads old data one half-cycle later, and the new data is read after the next accepted lookup. Under back-pressure the bench holds `rsp_ready` low for several edges, checks at each falling edge that the outputs are unchanged, and then checks that the queued request appears one edge after `rsp_ready` returns high.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    SP_MEM32 = 2'b00,
    SP_MEM64 = 2'b01,
    SP_IO    = 2'b10,
    SP_RSVD  = 2'b11
  } space_e;
endpackage

// File: rtl/xlat_index.sv
// Turns the high address field into a row select, clamping out-of-range values.
module xlat_index #(
  parameter int IW = 4,
  parameter int Q  = 16,
  localparam int SW = (Q > 1) ? $clog2(Q) : 1
) (
  input  logic [IW-1:0] addr_hi,
  output logic [SW-1:0] sel,
  output logic          err
);
  generate
    if (Q < (1 << IW)) begin : g_clamp
      always_comb begin
        if (int'(addr_hi) >= Q) begin
          sel = SW'(Q - 1);
          err = 1'b1;
        end else begin
          sel = SW'(addr_hi);
          err = 1'b0;
        end
      end
    end else begin : g_full
      assign sel = SW'(addr_hi);
      assign err = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/xlat_table.sv
// Q rows of {upper bits, space code}; one write port, one combinational read.
module xlat_table #(
  parameter int Q  = 16,
  parameter int IW = 4,
  parameter int HW = 20,
  localparam int SW = (Q > 1) ? $clog2(Q) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] wr_idx,
  input  logic [HW-1:0] wr_hi,
  input  logic [1:0]    wr_sp,
  input  logic [SW-1:0] rd_sel,
  output logic [HW-1:0] rd_hi,
  output logic [1:0]    rd_sp
);
  logic [HW-1:0] hi_q [Q];
  logic [1:0]    sp_q [Q];

  generate
    for (genvar g = 0; g < Q; g++) begin : g_row
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          hi_q[g] <= '0;
          sp_q[g] <= 2'b00;
        end else if (we && (int'(wr_idx) == g)) begin
          hi_q[g] <= wr_hi;
          sp_q[g] <= wr_sp;
        end
      end
    end
  endgenerate

  assign rd_hi = hi_q[rd_sel];
  assign rd_sp = sp_q[rd_sel];
endmodule

// File: rtl/xlat_stage.sv
// Output register with valid/ready; masks bits above 31 unless 64-bit space.
module xlat_stage
  import xlat_pkg::*;
#(
  parameter int P = 32,
  parameter int N = 12,
  localparam int HW = P - N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N-1:0]  in_lo,
  input  logic [HW-1:0] in_hi,
  input  logic [1:0]    in_sp,
  input  logic          in_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [P-1:0]  out_addr,
  output logic [1:0]    out_space,
  output logic          out_err
);
  logic [HW-1:0] hi_m;

  generate
    if (P > 32) begin : g_mask
      localparam int UB = P - 32;
      assign hi_m = (space_e'(in_sp) == SP_MEM64) ? in_hi
                  : {{UB{1'b0}}, in_hi[HW-UB-1:0]};
    end else begin : g_nomask
      assign hi_m = in_hi;
    end
  endgenerate

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_space <= 2'b00;
      out_err   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr  <= {hi_m, in_lo};
        out_space <= in_sp;
        out_err   <= in_err;
      end
    end
  end
endmodule

// File: rtl/xlat_window.sv
module xlat_window #(
  parameter int N = 12,
  parameter int M = 16,
  parameter int P = 32,
  parameter int Q = 16,
  localparam int IW = M - N,
  localparam int HW = P - N,
  localparam int SW = (Q > 1) ? $clog2(Q) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [M-1:0]  req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [P-1:0]  rsp_addr,
  output logic [1:0]    rsp_space,
  output logic          rsp_err,
  input  logic          tbl_we,
  input  logic [IW-1:0] tbl_idx,
  input  logic [HW-1:0] tbl_hi,
  input  logic [1:0]    tbl_space
);
  logic [SW-1:0] sel;
  logic          idx_err;
  logic [HW-1:0] row_hi;
  logic [1:0]    row_sp;

  xlat_index #(.IW(IW), .Q(Q)) u_index (
    .addr_hi (req_addr[M-1:N]),
    .sel     (sel),
    .err     (idx_err)
  );

  xlat_table #(.Q(Q), .IW(IW), .HW(HW)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (tbl_we),
    .wr_idx (tbl_idx),
    .wr_hi  (tbl_hi),
    .wr_sp  (tbl_space),
    .rd_sel (sel),
    .rd_hi  (row_hi),
    .rd_sp  (row_sp)
  );

  xlat_stage #(.P(P), .N(N)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_lo     (req_addr[N-1:0]),
    .in_hi     (row_hi),
    .in_sp     (row_sp),
    .in_err    (idx_err),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_addr  (rsp_addr),
    .out_space (rsp_space),
    .out_err   (rsp_err)
  );
endmodule

// File: rtl/xlat_window_chk.sv
module xlat_window_chk #(
  parameter int N = 12,
  parameter int M = 16,
  parameter int P = 32,
  parameter int Q = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic [M-1:0] req_addr,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [P-1:0] rsp_addr,
  input logic [1:0]   rsp_space,
  input logic         rsp_err
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

  // R5
  accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R2
  low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_addr[N-1:0] == $past(req_addr[N-1:0])));

  // R8
  range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_err == (int'($past(req_addr[M-1:N])) >= Q)));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr)
                                   && $stable(rsp_space) && $stable(rsp_err)));

  // R6
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind xlat_window xlat_window_chk #(.N(N), .M(M), .P(P), .Q(Q)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_addr  (rsp_addr),
  .rsp_space (rsp_space),
  .rsp_err   (rsp_err)
);

// File: tb/xlat_window_tb.sv
module xlat_window_tb;
  localparam int N  = 12;
  localparam int M  = 16;
  localparam int P  = 32;
  localparam int Q  = 12;
  localparam int IW = M - N;
  localparam int HW = P - N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [M-1:0]  req_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [P-1:0]  rsp_addr;
  logic [1:0]    rsp_space;
  logic          rsp_err;
  logic          tbl_we = 1'b0;
  logic [IW-1:0] tbl_idx = '0;
  logic [HW-1:0] tbl_hi = '0;
  logic [1:0]    tbl_space = 2'b00;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [HW-1:0] m_hi [Q];
  logic [1:0]    m_sp [Q];

  always #5 clk = ~clk;

  xlat_window #(.N(N), .M(M), .P(P), .Q(Q)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_space(rsp_space), .rsp_err(rsp_err),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_hi(tbl_hi), .tbl_space(tbl_space)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int row_of(logic [M-1:0] a);
    int i = int'(a[M-1:N]);
    return (i >= Q) ? Q - 1 : i;
  endfunction

  // Full compare of one result against the bench model.
  task automatic expect_rsp(string req, logic [M-1:0] a);
    int r = row_of(a);
    check({req, " valid"}, 64'(rsp_valid), 64'd1);
    check({req, " addr"}, 64'(rsp_addr), 64'({m_hi[r], a[N-1:0]}));
    check({req, " space"}, 64'(rsp_space), 64'(m_sp[r]));
    check({req, " err"}, 64'(rsp_err), 64'(int'(a[M-1:N]) >= Q));
  endtask

  task automatic wr(int idx, logic [HW-1:0] hi, logic [1:0] sp);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = IW'(idx); tbl_hi = hi; tbl_space = sp;
    @(negedge clk);
    tbl_we = 1'b0;
    if (idx < Q) begin m_hi[idx] = hi; m_sp[idx] = sp; end
  endtask

  // Issues one lookup on a falling edge; result is due at the next falling edge.
  task automatic lookup(string req, logic [M-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp(req, a);
  endtask

  task automatic t_reset();
    for (int i = 0; i < Q; i++) begin m_hi[i] = '0; m_sp[i] = 2'b00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 req_ready", 64'(req_ready), 64'd1);
    lookup("R1", 16'h7ABC);
    lookup("R1", 16'hB001);
  endtask

  task automatic t_basic();
    wr(0, 20'hABCDE, 2'b00);
    wr(3, 20'h12345, 2'b01);
    wr(7, 20'hFFFFF, 2'b10);
    wr(11, 20'h0F0F0, 2'b11);
    lookup("R3", 16'h0123);
    lookup("R2", 16'h3FFF);
    lookup("R4", 16'h7000);
    lookup("R4", 16'hB555);
    lookup("R2", 16'h3000);
  endtask

  task automatic t_stream();
    // Back-to-back lookups: each accepted edge yields a result one edge later.
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0AAA;
    @(negedge clk);
    expect_rsp("R5 first", 16'h0AAA);
    req_addr = 16'h3555;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R5 second", 16'h3555);
    @(negedge clk);
    check("R5 drained", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_backpressure();
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h7123;
    @(negedge clk);
    expect_rsp("R6 held", 16'h7123);
    check("R6 req_ready low", 64'(req_ready), 64'd0);
    req_addr = 16'h0456;
    repeat (2) begin
      @(negedge clk);
      expect_rsp("R6 held", 16'h7123);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R6 released", 16'h0456);
  endtask

  task automatic t_same_edge();
    logic [HW-1:0] old_hi = m_hi[3];
    logic [1:0]    old_sp = m_sp[3];
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h3777;
    tbl_we = 1'b1; tbl_idx = 4'd3; tbl_hi = 20'h55AA5; tbl_space = 2'b10;
    @(negedge clk);
    req_valid = 1'b0; tbl_we = 1'b0;
    check("R7 old addr", 64'(rsp_addr), 64'({old_hi, 12'h777}));
    check("R7 old space", 64'(rsp_space), 64'(old_sp));
    m_hi[3] = 20'h55AA5; m_sp[3] = 2'b10;
    lookup("R7 new", 16'h3777);
  endtask

  task automatic t_range();
    wr(11, 20'h13579, 2'b01);
    lookup("R8 clamp", 16'hC0DE);
    lookup("R8 clamp", 16'hF001);
    lookup("R8 edge", 16'hB002);
    wr(13, 20'hEEEEE, 2'b11);
    wr(12, 20'hDDDDD, 2'b10);
    lookup("R9 row11", 16'hB234);
    lookup("R9 row0", 16'h0234);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_stream();
    t_backpressure();
    t_same_edge();
    t_range();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule